// File: doc/BRIEF.md
# Write Completion Poller

After the host has issued a program or erase command sequence to a nonvolatile memory, this block works out when the internal operation has finished. A one-cycle start pulse captures the polling mode, the operation kind, the target word address and the data that was written. The poller then reads that address over and over through a synchronous read port that has one request and one response. It judges each returned word against the rule for the chosen mode.

Two modes are supported. In toggle mode, bit 6 of successive reads stops changing once the operation is over. In data-polling mode, bit 7 of the read word equals the true bit 7 of the written data, or 1 for an erase. A read can coincide with the moment the memory finishes, so one word that looks finished is only a candidate. Two further reads must also pass before the poller reports completion. A failed confirmation is reported on `fail`, and the poller goes back to searching for a candidate.

Each operation kind has its own time limit, given in microseconds and scaled by the clock frequency in MHz. If the limit runs out first, the poller reports a timeout and returns to idle.

Top module: `wr_done_poller`

## Requirements
- R1: After reset, `busy`, `rd_req`, `done`, `fail` and `timeout` are all low.
- R2: `start` is accepted only while idle. It latches `mode`, `op`, `addr` and `wdata`. Every read of the operation uses the latched address. A `start` that arrives while `busy` is high has no effect on the address, the read count or the outcome.
- R3: At most one read is outstanding. `rd_req` is a one-cycle pulse, and the next pulse comes only after `rd_valid` has returned for the previous one.
- R4: Toggle mode (`mode`=0): a read passes when its bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation never passes.
- R5: Data-polling mode (`mode`=1): a read passes when its bit 7 equals the expected bit. The expected bit is `wdata[7]` when `op`=0 (program) and 1 when `op`=1 (sector or block erase) or `op`=2/3 (chip erase).
- R6: A passing read is a candidate. Completion needs the next two reads to pass as well. The poller then pulses `done` for one cycle in the same edge that drops `busy`.
- R7: If a confirmation read fails, `fail` pulses for one cycle. The candidate is dropped and polling goes on with the search for a new candidate.
- R8: The time limit in cycles is CLK_MHZ×PROG_US for `op`=0, CLK_MHZ×SECT_US for `op`=1, and CLK_MHZ×CHIP_US for `op`=2 or 3. If completion has not been confirmed within that many busy cycles, `timeout` pulses for one cycle, and `busy` falls after exactly that many cycles.
- R9: `done`, `fail` and `timeout` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| mode | input | 1 | 0 = toggle bit 6, 1 = data-polling bit 7 |
| op | input | 2 | 0 program, 1 sector/block erase, 2/3 chip erase |
| addr | input | AW | Word address to poll |
| wdata | input | DW | Data that was programmed |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DW | Read response word |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Completion confirmed (pulse) |
| fail | output | 1 | Candidate rejected by a confirmation read (pulse) |
| timeout | output | 1 | Limit reached before completion (pulse) |

## Verification
The assertions assume that the read port answers each `rd_req` with exactly one `rd_valid` and never sends a response that was not requested. They also assume that `start` is a single-cycle pulse. The bench responder returns one word per request after a fixed delay of two cycles and never otherwise. Its word sequences are scripted so that both real and false candidates occur, and so that the operation either finishes or runs until its limit. The bench drives `start` for exactly one cycle, including one extra start issued while the poller is busy.

// File: rtl/wr_done_poller.sv
module wr_done_poller #(
  parameter int CLK_MHZ = 125,
  parameter int AW      = 21,
  parameter int DW      = 16,
  parameter int PROG_US = 12,
  parameter int SECT_US = 25000,
  parameter int CHIP_US = 50000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          timeout
);
  localparam int PROG_CYC = CLK_MHZ * PROG_US;
  localparam int SECT_CYC = CLK_MHZ * SECT_US;
  localparam int CHIP_CYC = CLK_MHZ * CHIP_US;
  localparam int MAX_A    = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] PROG_LIM = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] SECT_LIM = TW'(SECT_CYC - 1);
  localparam logic [TW-1:0] CHIP_LIM = TW'(CHIP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t           st;
  logic          md, exp7, prev6, have_prev;
  logic [1:0]    opr, conf;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tmr;

  wire [TW-1:0] lim    = (opr == 2'd0) ? PROG_LIM : (opr == 2'd1) ? SECT_LIM : CHIP_LIM;
  wire          hit    = md ? (rd_data[7] == exp7) : (have_prev && rd_data[6] == prev6);
  wire          got    = (st == S_WAIT) && rd_valid;
  wire          finish = got && hit && (conf == 2'd2);
  wire          expire = (st != S_IDLE) && (tmr == lim);

  assign busy    = (st != S_IDLE);
  assign rd_req  = (st == S_REQ);
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= 1'b0; opr <= 2'd0; addr_q <= '0; exp7 <= 1'b0;
      prev6 <= 1'b0; have_prev <= 1'b0; conf <= 2'd0; tmr <= '0;
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          md <= mode; opr <= op; addr_q <= addr;
          exp7 <= (op == 2'd0) ? wdata[7] : 1'b1;
          have_prev <= 1'b0; conf <= 2'd0; tmr <= '0;
          st <= S_REQ;
        end
      end else begin
        tmr <= tmr + 1'b1;
        if (finish) begin
          done <= 1'b1; st <= S_IDLE;
        end else if (expire) begin
          timeout <= 1'b1; st <= S_IDLE;
        end else if (st == S_REQ) begin
          st <= S_WAIT;
        end else if (got) begin
          prev6 <= rd_data[6];
          have_prev <= 1'b1;
          if (hit) conf <= conf + 1'b1;
          else begin
            conf <= 2'd0;
            fail <= (conf != 2'd0);
          end
          st <= S_REQ;
        end
      end
    end
  end

  // R3
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req);
  // R9
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, fail, timeout}));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(rd_addr));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  fail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) fail |-> busy);
  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> (!busy && $past(busy)));
endmodule

// File: tb/tb_wr_done_poller.sv
module tb_wr_done_poller;
  localparam int AW = 21, DW = 16;
  localparam int PROG_CYC = 60, SECT_CYC = 90, CHIP_CYC = 120;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [1:0] op = 2'd0;
  logic [AW-1:0] addr = '0, rd_addr;
  logic [DW-1:0] wdata = '0, rd_data = '0;
  logic rd_req, rd_valid = 1'b0, busy, done, fail, timeout;

  always #4 clk = ~clk;

  wr_done_poller #(.CLK_MHZ(1), .AW(AW), .DW(DW), .PROG_US(PROG_CYC),
                   .SECT_US(SECT_CYC), .CHIP_US(CHIP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op(op), .addr(addr),
    .wdata(wdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .done(done), .fail(fail), .timeout(timeout));

  typedef struct { int kind; int val; string tag; } item_t;
  item_t exp_q[$];
  logic [DW-1:0] rsp_q[$];
  logic [DW-1:0] rsp_final = '0;
  bit rsp_hang = 0, hang_ph = 0;
  int pend = 0, total = 0, bad = 0, reads = 0, bcyc = 0, cyc = 0;
  logic [AW-1:0] exp_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic expect_item(input int kind, input int val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // responder: one word per request, two cycles later
  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        rd_valid <= 1'b1;
        if (rsp_q.size() > 0) rd_data <= rsp_q.pop_front();
        else if (rsp_hang) begin
          rd_data <= hang_ph ? 16'h0040 : 16'h0000;
          hang_ph = ~hang_ph;
        end else rd_data <= rsp_final;
      end
    end
    if (rd_req) pend = 2;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk($countones({done, fail, timeout}) <= 1, "R9 outcome pulses exclusive",
          $countones({done, fail, timeout}), 1);
      if (done || fail || timeout) begin
        int kind;
        kind = done ? 0 : (fail ? 1 : 2);
        if (exp_q.size() == 0) chk(0, "R6 unexpected outcome pulse", kind, -1);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(kind == it.kind, {it.tag, " kind"}, kind, it.kind);
          chk((kind == 2 ? bcyc : reads) == it.val, {it.tag, " count"},
              (kind == 2 ? bcyc : reads), it.val);
        end
      end
      if (rd_req) begin
        reads++;
        chk(rd_addr == exp_addr, "R2 read address", int'(rd_addr), int'(exp_addr));
      end
      if (busy) bcyc++;
      else begin reads = 0; bcyc = 0; end
    end
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input bit m, input logic [1:0] o, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input bit dbl);
    exp_addr = a;
    @(negedge clk);
    start = 1'b1; mode = m; op = o; addr = a; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    if (dbl) begin
      repeat (4) @(negedge clk);
      start = 1'b1; mode = 1'b0; op = 2'd2; addr = 21'h1FFFF; wdata = 16'h0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    rsp_q.delete(); rsp_hang = 0; hang_ph = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!rd_req, "R1 rd_req after reset", rd_req, 0);
    chk(!(done | fail | timeout), "R1 outcomes after reset", {done, fail, timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R1 idle without start", busy, 0);

    // R4 R6 toggle program: toggles twice, then settles
    rsp_q = '{16'h0040, 16'h0000, 16'h0040, 16'h0000}; rsp_final = 16'h1274;
    expect_item(0, 8, "R4 toggle settle");
    run(1'b0, 2'd0, 21'h00123, 16'h1274, 0);

    // R7 false toggle candidate rejected, then real completion
    rsp_q = '{16'h0040, 16'h0040, 16'h0000, 16'h0040}; rsp_final = 16'h0040;
    expect_item(1, 3, "R7 toggle reject");
    expect_item(0, 7, "R6 toggle after reject");
    run(1'b0, 2'd1, 21'h0A000, 16'h0000, 0);

    // R5 data polling program, wdata[7]=1, plus ignored second start (R2)
    rsp_q = '{16'h0025, 16'h0025}; rsp_final = 16'h00A5;
    expect_item(0, 5, "R5 R2 data program with ignored start");
    run(1'b1, 2'd0, 21'h1F00F, 16'h00A5, 1);

    // R5 data polling program, wdata[7]=0
    rsp_q = '{16'h0080, 16'h00FF}; rsp_final = 16'h0033;
    expect_item(0, 5, "R5 data program bit7 zero");
    run(1'b1, 2'd0, 21'h00042, 16'h0033, 0);

    // R5 erase expects 1 regardless of wdata
    rsp_q = '{16'h0000, 16'h0000}; rsp_final = 16'hFFFF;
    expect_item(0, 5, "R5 data erase");
    run(1'b1, 2'd1, 21'h08000, 16'h0000, 0);

    // R7 data polling false candidate
    rsp_q = '{16'h0000, 16'h0080, 16'h0000}; rsp_final = 16'hFFFF;
    expect_item(1, 3, "R7 data reject");
    expect_item(0, 6, "R6 data after reject");
    run(1'b1, 2'd2, 21'h00555, 16'h0000, 0);

    // R8 timeouts per operation kind
    rsp_hang = 1;
    expect_item(2, PROG_CYC, "R8 program limit");
    run(1'b0, 2'd0, 21'h00011, 16'h0000, 0);
    rsp_hang = 1;
    expect_item(2, SECT_CYC, "R8 sector limit");
    run(1'b1, 2'd1, 21'h00022, 16'h0000, 0);
    rsp_hang = 1;
    expect_item(2, CHIP_CYC, "R8 chip limit");
    run(1'b0, 2'd2, 21'h00033, 16'h0000, 0);
    rsp_hang = 1;
    expect_item(2, CHIP_CYC, "R8 op3 as chip");
    run(1'b1, 2'd3, 21'h00044, 16'h0000, 0);

    chk(exp_q.size() == 0, "R6 all outcomes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule